// File: doc/BRIEF.md
# Pulse-to-Pulse Adaptive Feed-Forward Learner

This block learns a correction waveform for disturbances that come back identically on every RF pulse, such as supply droop or mains ripple. While the pulse gate is high, each sample strobe compares the measured I/Q pair against the setpoint and stores the saturated difference at that sample's position in the pulse. After the gate falls, a sequencer adds a scaled copy of the stored error to the correction table one entry per clock. On the next pulse, the table is played back as a feed-forward I/Q term. The playback is aligned to the pulse start and indexed by the same strobe count. The feed-forward term is meant to be added to the feedback controller output outside this block.

The learning gain is a power of two, set as a right-shift amount. The table is held in two banks. The update writes the idle bank and swaps the banks only when the update has finished. A pulse that arrives early therefore always plays a complete table, either the old one or the new one, and never a partly updated one. An early pulse raises a sticky abort flag. A clear input wipes the table. An enable input forces the output to zero, but recording and learning continue while it is low.

Top module: `pulse_ff_learner`

## Requirements
- R1: After reset, ff_i, ff_q and upd_abort are 0, and every correction table entry is 0.
- R2: Sample index k counts the strobes seen while the gate is high, starting at 0 on the strobe in the cycle the gate rises (or the first strobe after that). For k < DEPTH, the recorded error is set minus meas, computed per lane and saturated to the signed DW-bit range.
- R3: On a strobe with gate high, ff_en high and k < DEPTH, the lane output takes table entry k in the clock edge of that strobe. The output holds that value until the next strobe.
- R4: In the clock edge where the gate is first seen low, an update starts. It replaces each entry k below the recorded sample count with sat(corr[k] + floor(err[k] / 2^gain_shift)), saturated to DW bits, and leaves the other entries unchanged. The new table takes effect DEPTH clock edges after the update starts.
- R5: A strobe with index k >= DEPTH drives the outputs to 0 and records nothing.
- R6: In any clock edge where the gate is low, the outputs become 0.
- R7: In any clock edge where ff_en is low, the outputs become 0. Errors are still recorded and the table is still updated.
- R8: If the gate rises while an update is in progress, the update is dropped and the whole previous table stays in use. upd_abort goes to 1 and stays there until an update completes or the table is cleared.
- R9: A one-cycle tbl_clr pulse zeroes the table, cancels any update in progress, clears upd_abort, and zeroes the outputs.
- R10: Table entries saturate at the signed DW-bit limits as learning accumulates over successive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_gate | input | 1 | High during the pulse flat-top |
| sample_stb | input | 1 | One-cycle strobe per I/Q sample |
| meas_i | input | DW | Measured in-phase value, signed |
| meas_q | input | DW | Measured quadrature value, signed |
| set_i | input | DW | In-phase setpoint, signed |
| set_q | input | DW | Quadrature setpoint, signed |
| gain_shift | input | GSW | Learning gain as a right-shift amount |
| ff_en | input | 1 | Enables the feed-forward output |
| tbl_clr | input | 1 | Zeroes the correction table |
| ff_i | output | DW | Feed-forward in-phase term, signed |
| ff_q | output | DW | Feed-forward quadrature term, signed |
| upd_abort | output | 1 | Sticky flag: an update was cut short by a pulse |

## Verification
The assertions check the output-forcing rules on every cycle: zero output when the gate is low, when the block is disabled, and when a strobe falls past the table depth. They also check that an update never overlaps a pulse, that an abort keeps the active bank and sets the flag, that a completed update swaps the banks, and that a clear resets the sequencer. The stored numbers themselves can only be shown by the bench scenarios, which play back the next pulse. These cover the per-index error capture, the shift-scaled accumulation and saturation, learning while disabled, the discarded update after an early pulse, and a clear issued in the middle of an update.

// File: rtl/pff_pkg.sv
package pff_pkg;

  // Clamp a wide value into the signed range of a w-bit word.
  function automatic longint clamp_w(longint v, int unsigned w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Flat-top error: setpoint minus measurement, saturated.
  function automatic longint err_of(longint sp, longint ms, int unsigned w);
    return clamp_w(sp - ms, w);
  endfunction

  // One learning step: add the error scaled by 2^-sh, saturated.
  function automatic longint learn_step(longint c, longint e, int unsigned sh, int unsigned w);
    return clamp_w(c + (e >>> sh), w);
  endfunction

endpackage

// File: rtl/pff_index.sv
module pff_index #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_gate,
  input  logic          sample_stb,
  output logic          pulse_rise,
  output logic          pulse_fall,
  output logic          cap_we,
  output logic          cap_over,
  output logic [AW-1:0] cap_addr,
  output logic [AW:0]   rec_len
);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic        gate_q;
  logic [AW:0] cnt;
  logic [AW:0] cur;
  logic        hit;
  logic        in_range;

  assign pulse_rise = pulse_gate & ~gate_q;
  assign pulse_fall = ~pulse_gate & gate_q;
  assign cur        = pulse_rise ? '0 : cnt;
  assign hit        = pulse_gate & sample_stb;
  assign in_range   = cur < DEPTH_C;
  assign cap_we     = hit & in_range;
  assign cap_over   = hit & ~in_range;
  assign cap_addr   = cur[AW-1:0];
  assign rec_len    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt    <= '0;
    end else begin
      gate_q <= pulse_gate;
      if (cap_we)          cnt <= cur + 1'b1;
      else if (pulse_rise) cnt <= '0;
    end
  end
endmodule

// File: rtl/pff_err_buf.sv
module pff_err_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] set_v,
  input  logic signed [DW-1:0] meas_v,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [DW-1:0] rd_err
);
  logic signed [DW-1:0] mem [DEPTH];
  logic signed [DW-1:0] err_now;

  assign err_now = DW'(pff_pkg::err_of(longint'(set_v), longint'(meas_v), DW));
  assign rd_err  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= err_now;
  end
endmodule

// File: rtl/pff_corr_bank.sv
module pff_corr_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int GSW   = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 act,
  input  logic [AW-1:0]        play_addr,
  input  logic [AW-1:0]        upd_addr,
  input  logic                 upd_we,
  input  logic                 upd_in_len,
  input  logic [GSW-1:0]       gain_shift,
  input  logic signed [DW-1:0] err_in,
  output logic signed [DW-1:0] play_val
);
  logic signed [DW-1:0] tbl [2][DEPTH];
  logic signed [DW-1:0] old_v;
  logic signed [DW-1:0] new_v;

  assign old_v    = tbl[act][upd_addr];
  assign new_v    = upd_in_len
                  ? DW'(pff_pkg::learn_step(longint'(old_v), longint'(err_in),
                                            int'(gain_shift), DW))
                  : old_v;
  assign play_val = tbl[act][play_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < DEPTH; k++) tbl[b][k] <= '0;
    end else if (clr) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < DEPTH; k++) tbl[b][k] <= '0;
    end else if (upd_we) begin
      tbl[~act][upd_addr] <= new_v;
    end
  end
endmodule

// File: rtl/pff_update_seq.sv
module pff_update_seq #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_rise,
  input  logic          pulse_fall,
  input  logic          clr,
  input  logic [AW:0]   rec_len,
  output logic          busy,
  output logic [AW-1:0] upd_addr,
  output logic          upd_we,
  output logic          upd_in_len,
  output logic          commit,
  output logic          abort_evt,
  output logic          act_bank
);
  localparam logic [AW-1:0] LAST_K = AW'(DEPTH - 1);

  logic [AW-1:0] k;

  assign upd_addr   = k;
  assign upd_we     = busy & ~pulse_rise & ~clr;
  assign commit     = upd_we & (k == LAST_K);
  assign abort_evt  = busy & pulse_rise & ~clr;
  assign upd_in_len = {1'b0, k} < rec_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      k        <= '0;
      act_bank <= 1'b0;
    end else if (clr) begin
      busy     <= 1'b0;
      k        <= '0;
      act_bank <= 1'b0;
    end else if (abort_evt) begin
      busy <= 1'b0;
    end else if (pulse_fall) begin
      busy <= 1'b1;
      k    <= '0;
    end else if (busy) begin
      k <= k + 1'b1;
      if (commit) begin
        busy     <= 1'b0;
        act_bank <= ~act_bank;
      end
    end
  end
endmodule

// File: rtl/pulse_ff_learner.sv
module pulse_ff_learner #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int GSW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pulse_gate,
  input  logic                 sample_stb,
  input  logic signed [DW-1:0] meas_i,
  input  logic signed [DW-1:0] meas_q,
  input  logic signed [DW-1:0] set_i,
  input  logic signed [DW-1:0] set_q,
  input  logic [GSW-1:0]       gain_shift,
  input  logic                 ff_en,
  input  logic                 tbl_clr,
  output logic signed [DW-1:0] ff_i,
  output logic signed [DW-1:0] ff_q,
  output logic                 upd_abort
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LANES = 2;

  logic          pulse_rise, pulse_fall, cap_we, cap_over;
  logic [AW-1:0] cap_addr, upd_addr;
  logic [AW:0]   rec_len;
  logic          upd_busy, upd_we, upd_in_len, upd_commit, abort_evt, act_bank;

  logic signed [DW-1:0] meas_l [LANES];
  logic signed [DW-1:0] set_l  [LANES];
  logic signed [DW-1:0] ff_l   [LANES];

  assign meas_l[0] = meas_i;
  assign meas_l[1] = meas_q;
  assign set_l[0]  = set_i;
  assign set_l[1]  = set_q;
  assign ff_i      = ff_l[0];
  assign ff_q      = ff_l[1];

  pff_index #(.DEPTH(DEPTH), .AW(AW)) u_index (
    .clk(clk), .rst_n(rst_n), .pulse_gate(pulse_gate), .sample_stb(sample_stb),
    .pulse_rise(pulse_rise), .pulse_fall(pulse_fall), .cap_we(cap_we),
    .cap_over(cap_over), .cap_addr(cap_addr), .rec_len(rec_len)
  );

  pff_update_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pulse_rise(pulse_rise), .pulse_fall(pulse_fall),
    .clr(tbl_clr), .rec_len(rec_len), .busy(upd_busy), .upd_addr(upd_addr),
    .upd_we(upd_we), .upd_in_len(upd_in_len), .commit(upd_commit),
    .abort_evt(abort_evt), .act_bank(act_bank)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic signed [DW-1:0] err_rd;
    logic signed [DW-1:0] play_v;

    pff_err_buf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_err (
      .clk(clk), .we(cap_we), .wr_addr(cap_addr), .set_v(set_l[ln]),
      .meas_v(meas_l[ln]), .rd_addr(upd_addr), .rd_err(err_rd)
    );

    pff_corr_bank #(.DW(DW), .DEPTH(DEPTH), .GSW(GSW), .AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .act(act_bank),
      .play_addr(cap_addr), .upd_addr(upd_addr), .upd_we(upd_we),
      .upd_in_len(upd_in_len), .gain_shift(gain_shift), .err_in(err_rd),
      .play_val(play_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ff_l[ln] <= '0;
      else if (!pulse_gate || !ff_en || tbl_clr) ff_l[ln] <= '0;
      else if (cap_we)                        ff_l[ln] <= play_v;
      else if (cap_over)                      ff_l[ln] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          upd_abort <= 1'b0;
    else if (tbl_clr)    upd_abort <= 1'b0;
    else if (abort_evt)  upd_abort <= 1'b1;
    else if (upd_commit) upd_abort <= 1'b0;
  end
endmodule

// File: rtl/pulse_ff_learner_chk.sv
module pulse_ff_learner_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pulse_gate,
  input logic                 ff_en,
  input logic                 tbl_clr,
  input logic signed [DW-1:0] ff_i,
  input logic signed [DW-1:0] ff_q,
  input logic                 upd_abort,
  input logic                 upd_busy,
  input logic                 pulse_rise,
  input logic                 cap_over,
  input logic                 upd_commit,
  input logic                 abort_evt,
  input logic                 act_bank
);
  p_gate_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_gate |=> (ff_i == '0 && ff_q == '0));

  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_en |=> (ff_i == '0 && ff_q == '0));

  p_past_depth_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_over |=> (ff_i == '0 && ff_q == '0));

  p_update_in_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_busy && pulse_gate) |-> pulse_rise);

  p_commit_swaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_commit |=> (act_bank != $past(act_bank)));

  p_abort_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (upd_abort && !upd_busy));

  p_abort_keeps_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> $stable(act_bank));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clr |=> (!upd_abort && !upd_busy && !act_bank && ff_i == '0 && ff_q == '0));
endmodule

bind pulse_ff_learner pulse_ff_learner_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_gate(pulse_gate), .ff_en(ff_en),
  .tbl_clr(tbl_clr), .ff_i(ff_i), .ff_q(ff_q), .upd_abort(upd_abort),
  .upd_busy(upd_busy), .pulse_rise(pulse_rise), .cap_over(cap_over),
  .upd_commit(upd_commit), .abort_evt(abort_evt), .act_bank(act_bank)
);

// File: tb/pulse_ff_learner_tb.sv
`timescale 1ns/1ps
module pulse_ff_learner_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int GSW   = 4;
  localparam int MAXV  = 2**(DW-1) - 1;
  localparam int MINV  = -(2**(DW-1));
  localparam int NV    = 8;
  // per row: samples, meas_i start, meas_q start, set_i, set_q, gain shift
  localparam int VEC [NV][6] = '{
    '{ 8,   100,   -50,    400,   300, 0},
    '{ 8,   100,   -50,    400,   300, 1},
    '{12,  -200,    50,      0,     0, 2},
    '{16,  1000, -1000,   1200,  -900, 3},
    '{ 4,     0,     0,      0,     0, 0},
    '{10, 30000, -30000, -30000, 30000, 0},
    '{10, 30000, -30000, -30000, 30000, 0},
    '{ 4,     0,     0,      0,     0, 15}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_gate = 1'b0, sample_stb = 1'b0, ff_en = 1'b1, tbl_clr = 1'b0;
  logic signed [DW-1:0] meas_i = '0, meas_q = '0, set_i = '0, set_q = '0;
  logic [GSW-1:0] gain_shift = '0;
  logic signed [DW-1:0] ff_i, ff_q;
  logic upd_abort;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int m_ci [DEPTH], m_cq [DEPTH], m_ei [DEPTH], m_eq [DEPTH];
  int m_len = 0;

  always #2 clk = ~clk;

  pulse_ff_learner #(.DW(DW), .DEPTH(DEPTH), .GSW(GSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_gate(pulse_gate), .sample_stb(sample_stb),
    .meas_i(meas_i), .meas_q(meas_q), .set_i(set_i), .set_q(set_q),
    .gain_shift(gain_shift), .ff_en(ff_en), .tbl_clr(tbl_clr),
    .ff_i(ff_i), .ff_q(ff_q), .upd_abort(upd_abort)
  );

  function automatic int bsat(int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  // floor division by 2^sh, written without a shift operator
  function automatic int bscale(int e, int sh);
    int d;
    d = 1;
    for (int i = 0; i < sh; i++) d = d * 2;
    if (e >= 0) return e / d;
    return -((-e + d - 1) / d);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one pulse of n strobes; strobe every other cycle and check playback.
  task automatic do_pulse(int n, int mi0, int mq0, int si, int sq, string req);
    int ei, eq;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk({req, " R3 hold I"}, int'(ff_i), ei);
        chk({req, " R3 hold Q"}, int'(ff_q), eq);
      end
      pulse_gate = 1'b1;
      sample_stb = 1'b1;
      meas_i = DW'(mi0 + 7*k);
      meas_q = DW'(mq0 - 5*k);
      set_i  = DW'(si);
      set_q  = DW'(sq);
      ei = (ff_en && k < DEPTH) ? m_ci[k] : 0;
      eq = (ff_en && k < DEPTH) ? m_cq[k] : 0;
      if (k < DEPTH) begin
        m_ei[k] = bsat(si - (mi0 + 7*k));
        m_eq[k] = bsat(sq - (mq0 - 5*k));
      end
      @(negedge clk);
      sample_stb = 1'b0;
      chk({req, (k < DEPTH) ? " R2 R3 play I" : " R5 over I"}, int'(ff_i), ei);
      chk({req, (k < DEPTH) ? " R2 R3 play Q" : " R5 over Q"}, int'(ff_q), eq);
    end
    m_len = (n < DEPTH) ? n : DEPTH;
    @(negedge clk);
    pulse_gate = 1'b0;
    @(negedge clk);
    chk({req, " R6 gate low I"}, int'(ff_i), 0);
    chk({req, " R6 gate low Q"}, int'(ff_q), 0);
  endtask

  // Gap long enough for the update; apply the bench's own learning rule.
  task automatic gap_full();
    repeat (DEPTH + 4) @(negedge clk);
    for (int k = 0; k < m_len; k++) begin
      m_ci[k] = bsat(m_ci[k] + bscale(m_ei[k], int'(gain_shift)));
      m_cq[k] = bsat(m_cq[k] + bscale(m_eq[k], int'(gain_shift)));
    end
    chk("R8 flag clear after completed update", int'(upd_abort), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      m_ci[k] = 0; m_cq[k] = 0; m_ei[k] = 0; m_eq[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset ff_i", int'(ff_i), 0);
    chk("R1 reset ff_q", int'(ff_q), 0);
    chk("R1 reset abort", int'(upd_abort), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven learning; the first pulse also shows the zeroed table (R1)
    for (int v = 0; v < NV; v++) begin
      gain_shift = GSW'(VEC[v][5]);
      do_pulse(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
               (v == 0) ? "R1 R4 vec" : (v >= 5) ? "R10 R4 vec" : "R4 vec");
      gap_full();
    end
    chk("R10 saturated entry I", m_ci[0], MINV);

    // past the table depth
    gain_shift = GSW'(1);
    do_pulse(DEPTH + 3, 50, 60, 10, 20, "R5 deep");
    gap_full();
    do_pulse(6, 0, 0, 0, 0, "R5 after deep");
    gap_full();

    // early pulse aborts the update
    gain_shift = GSW'(0);
    do_pulse(6, 10, 10, 500, -500, "R8 first");
    repeat (3) @(negedge clk);
    do_pulse(6, 0, 0, 100, 100, "R8 old table");
    chk("R8 abort flag set", int'(upd_abort), 1);
    gap_full();
    do_pulse(6, 0, 0, 0, 0, "R8 next");
    gap_full();

    // disabled output still learns
    ff_en = 1'b0;
    do_pulse(5, 0, 0, 300, -300, "R7 disabled");
    gap_full();
    ff_en = 1'b1;
    do_pulse(5, 0, 0, 0, 0, "R7 learned");
    gap_full();

    // clear in the middle of an update
    do_pulse(5, 0, 0, 200, 200, "R9 before");
    repeat (2) @(negedge clk);
    tbl_clr = 1'b1;
    @(negedge clk);
    tbl_clr = 1'b0;
    chk("R9 clear abort flag", int'(upd_abort), 0);
    for (int k = 0; k < DEPTH; k++) begin m_ci[k] = 0; m_cq[k] = 0; end
    repeat (DEPTH + 4) @(negedge clk);
    do_pulse(5, 0, 0, 0, 0, "R9 zeroed");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule